// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits between a host bus and a small model of a block-erasable NOR flash array. Each host write cycle is taken as a command byte or as the operand of a pending command. The block keeps track of what a read returns: array contents, identifier bytes or the status byte. It runs two-cycle program and erase operations. An erase in progress can be paused and later resumed.

A write cycle is the span during which both `cs_n` and `we_n` are low. The cycle is taken when the first of the two strobes goes high. The address and data used are those present in the last clock cycle of that span. Program and erase each hold `busy_o` for a fixed number of cycles set by a parameter, and the array changes only when the operation completes. Program ANDs the new data into the stored word, so bits can only be cleared. Erase sets every word of the addressed block to all ones. The array is `2**ADDR_W` words, split into `2**BLK_W` blocks selected by the top address bits. Block `BOOT_BLK` is the protected block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, reads return array data, every array word is all ones, `busy_o` is low and the status byte is 80h.
- R2: A write cycle takes effect only when `cs_n` or `we_n` rises after both were low. It has no effect while both stay low, and raising either strobe alone completes it.
- R3: Writing FFh selects array reads. Writing 90h selects identifier reads, which return MFR_ID when `addr[0]`=0 and DEV_ID when `addr[0]`=1.
- R4: Writing 70h selects status reads. Writing 50h clears the three error bits. The status byte layout is: bit7 ready, bit6 erase paused, bit5 erase error, bit4 program error, bit3 voltage error, bits 2..0 zero.
- R5: 40h or 10h, followed by a write cycle that carries the address and data, programs the word. The stored word becomes old AND data. `busy_o` is high for PROG_CYC cycles, and status bit7 reads 0 during that time.
- R6: 20h followed by D0h erases the block addressed in the D0h cycle. Every word of that block becomes all ones, other blocks are unchanged, and `busy_o` is high for ERASE_CYC cycles.
- R7: 20h followed by any byte other than D0h sets status bits 5 and 4 and erases nothing.
- R8: B0h during an erase pauses it. While paused, `busy_o` is low, status reads C0h when no errors are set, and array reads show the old contents. Only 70h, FFh and D0h are acted on; any other byte is ignored. D0h resumes the erase for its remaining cycles.
- R9: A program or erase issued while `vpp_ok` is low sets bit3 together with bit4 (program) or bit5 (erase). It starts nothing and leaves the array unchanged.
- R10: A program or erase aimed at block BOOT_BLK while `hv_unlock` and `boot_wr_ok` are both low sets bit4 (program) or bit5 (erase) and changes nothing. If either input is high, the operation proceeds.
- R11: Any first-cycle byte that is not a defined command (00h, D0h alone, E7h and so on) sets status bits 5 and 4 and selects status reads.
- R12: The second cycle of a program or erase sequence selects status reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Word address for writes and reads |
| wdata | input | DATA_W | Command byte or program data |
| rdata | output | DATA_W | Read data for the current `addr` and read mode |
| vpp_ok | input | 1 | Programming voltage is valid |
| hv_unlock | input | 1 | High-voltage unlock of the protected block |
| boot_wr_ok | input | 1 | Write-protect release for the protected block |
| busy_o | output | 1 | A program or erase is running |

## Verification
The bench drives a write that holds both strobes low for several cycles and then releases only chip select. A design that fires on the falling edge of the strobe, or only on `we_n`, changes the read mode early or never. It programs the same word twice with overlapping patterns, so a design that overwrites the word instead of ANDing into it returns the second pattern. The bench pauses an erase, feeds the block a program setup and an identifier command, then counts the busy cycles left after resume. A design that accepts 40h while paused would start a program, and a timer that keeps counting while paused would finish early. Protection is checked for each release input alone and for neither, and the low-voltage path is checked for both operations.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG_ARM,
        ST_ERASE_ARM,
        ST_PROG_RUN,
        ST_ERASE_RUN,
        ST_ERASE_HOLD
    } op_state_e;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_IDENT,
        RM_STATUS
    } rd_mode_e;

    localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_RD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_RD_STATUS = 8'h70;
    localparam logic [7:0] CMD_CLR_ERR   = 8'h50;
    localparam logic [7:0] CMD_ERASE_ARM = 8'h20;
    localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
    localparam logic [7:0] CMD_PROG_A    = 8'h40;
    localparam logic [7:0] CMD_PROG_B    = 8'h10;
    localparam logic [7:0] CMD_PAUSE     = 8'hB0;

    // error field order inside the controller: {erase, program, voltage}
    localparam int ERR_ERASE = 2;
    localparam int ERR_PROG  = 1;
    localparam int ERR_VOLT  = 0;

endpackage

// File: rtl/fcc_op_timer.sv
module fcc_op_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    input  logic             hold,
    output logic             done,
    output logic             running
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign running = (cnt_q != '0);
    assign done    = running && !hold && (cnt_q == CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = len;
        else if (running && !hold)
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8: a paused count does not move
    p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && hold && !start) |=> $stable(cnt_q));

    // R6: a started operation is counting on the next cycle
    p_start_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && len != '0) |=> running);

endmodule

// File: rtl/fcc_cell_array.sv
module fcc_cell_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int BLK_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic              erase_en,
    input  logic [BLK_W-1:0]  erase_blk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int BLK_LSB = ADDR_W - BLK_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] old_data;

    assign rd_data  = mem_q[rd_addr];
    assign old_data = mem_q[prog_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) mem_q[w] <= '1;
        end else begin
            for (int w = 0; w < DEPTH; w++) begin
                if (erase_en && ((w >> BLK_LSB) == int'(erase_blk)))
                    mem_q[w] <= '1;
                else if (prog_en && (int'(prog_addr) == w))
                    mem_q[w] <= mem_q[w] & prog_data;
            end
        end
    end

    // R5: programming never raises a bit
    p_prog_clear_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en && !erase_en) |=> ((mem_q[$past(prog_addr)] & ~$past(old_data)) == '0));

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter int         DATA_W    = 8,
    parameter int         BLK_W     = 2,
    parameter int         BOOT_BLK  = 0,
    parameter int         CNT_W     = 8,
    parameter int         PROG_CYC  = 4,
    parameter int         ERASE_CYC = 12,
    parameter logic [7:0] MFR_ID    = 8'hA7,
    parameter logic [7:0] DEV_ID    = 8'h5E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              vpp_ok,
    input  logic              hv_unlock,
    input  logic              boot_wr_ok,
    output logic              busy_o
);
    localparam int BLK_LSB = ADDR_W - BLK_W;

    typedef struct packed {
        op_state_e         st;
        rd_mode_e          mode;
        logic [2:0]        err;
        logic              act;
        logic [ADDR_W-1:0] ca;
        logic [DATA_W-1:0] cd;
        logic [ADDR_W-1:0] pa;
        logic [DATA_W-1:0] pd;
    } ctrl_t;

    ctrl_t r_d, r_q;

    logic             act_now, fire, locked, t_start, t_done, t_run, t_hold;
    logic             prog_en, erase_en;
    logic [CNT_W-1:0] t_len;
    logic [7:0]       cmd, stat8;
    logic [DATA_W-1:0] arr_rd;

    assign act_now = !cs_n && !we_n;
    assign fire    = r_q.act && !act_now;
    assign cmd     = r_q.cd[7:0];
    assign locked  = (r_q.ca[ADDR_W-1:BLK_LSB] == BLK_W'(BOOT_BLK)) && !(hv_unlock || boot_wr_ok);
    assign busy_o  = (r_q.st == ST_PROG_RUN) || (r_q.st == ST_ERASE_RUN);
    assign t_hold  = (r_q.st == ST_ERASE_HOLD);
    assign stat8   = {!busy_o, t_hold, r_q.err, 3'b000};

    always_comb begin
        r_d      = r_q;
        r_d.act  = act_now;
        t_start  = 1'b0;
        t_len    = '0;
        prog_en  = 1'b0;
        erase_en = 1'b0;
        if (act_now) begin
            r_d.ca = addr;
            r_d.cd = wdata;
        end
        case (r_q.st)
            ST_IDLE: if (fire) begin
                case (cmd)
                    CMD_RD_ARRAY:             r_d.mode = RM_ARRAY;
                    CMD_RD_IDENT:             r_d.mode = RM_IDENT;
                    CMD_RD_STATUS:            r_d.mode = RM_STATUS;
                    CMD_CLR_ERR:              r_d.err  = '0;
                    CMD_PROG_A, CMD_PROG_B:   r_d.st   = ST_PROG_ARM;
                    CMD_ERASE_ARM:            r_d.st   = ST_ERASE_ARM;
                    CMD_PAUSE:                ;
                    default: begin
                        r_d.err[ERR_ERASE] = 1'b1;
                        r_d.err[ERR_PROG]  = 1'b1;
                        r_d.mode           = RM_STATUS;
                    end
                endcase
            end
            ST_PROG_ARM: if (fire) begin
                r_d.mode = RM_STATUS;
                r_d.st   = ST_IDLE;
                if (!vpp_ok) begin
                    r_d.err[ERR_VOLT] = 1'b1;
                    r_d.err[ERR_PROG] = 1'b1;
                end else if (locked) begin
                    r_d.err[ERR_PROG] = 1'b1;
                end else begin
                    r_d.pa  = r_q.ca;
                    r_d.pd  = r_q.cd;
                    r_d.st  = ST_PROG_RUN;
                    t_start = 1'b1;
                    t_len   = CNT_W'(PROG_CYC);
                end
            end
            ST_ERASE_ARM: if (fire) begin
                r_d.mode = RM_STATUS;
                r_d.st   = ST_IDLE;
                if (cmd != CMD_CONFIRM) begin
                    r_d.err[ERR_ERASE] = 1'b1;
                    r_d.err[ERR_PROG]  = 1'b1;
                end else if (!vpp_ok) begin
                    r_d.err[ERR_VOLT]  = 1'b1;
                    r_d.err[ERR_ERASE] = 1'b1;
                end else if (locked) begin
                    r_d.err[ERR_ERASE] = 1'b1;
                end else begin
                    r_d.pa  = r_q.ca;
                    r_d.st  = ST_ERASE_RUN;
                    t_start = 1'b1;
                    t_len   = CNT_W'(ERASE_CYC);
                end
            end
            ST_PROG_RUN: if (t_done) begin
                prog_en = 1'b1;
                r_d.st  = ST_IDLE;
            end
            ST_ERASE_RUN: begin
                if (t_done) begin
                    erase_en = 1'b1;
                    r_d.st   = ST_IDLE;
                end else if (fire && cmd == CMD_PAUSE) begin
                    r_d.st   = ST_ERASE_HOLD;
                    r_d.mode = RM_STATUS;
                end
            end
            ST_ERASE_HOLD: if (fire) begin
                case (cmd)
                    CMD_RD_STATUS: r_d.mode = RM_STATUS;
                    CMD_RD_ARRAY:  r_d.mode = RM_ARRAY;
                    CMD_CONFIRM: begin
                        r_d.st   = ST_ERASE_RUN;
                        r_d.mode = RM_STATUS;
                    end
                    default: ;
                endcase
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    fcc_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (t_start),
        .len     (t_len),
        .hold    (t_hold),
        .done    (t_done),
        .running (t_run)
    );

    fcc_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_addr (r_q.pa),
        .prog_data (r_q.pd),
        .erase_en  (erase_en),
        .erase_blk (r_q.pa[ADDR_W-1:BLK_LSB]),
        .rd_addr   (addr),
        .rd_data   (arr_rd)
    );

    always_comb begin
        case (r_q.mode)
            RM_ARRAY: rdata = arr_rd;
            RM_IDENT: rdata = DATA_W'(addr[0] ? DEV_ID : MFR_ID);
            default:  rdata = DATA_W'(stat8);
        endcase
    end

    // R8: a paused erase never completes and keeps its remaining count
    p_hold_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        t_hold |-> (!t_done && t_run));

    // R9: second cycle with the supply low starts nothing
    p_vpp_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_PROG_ARM || r_q.st == ST_ERASE_ARM) && fire && !vpp_ok) |=> !busy_o);

    // R10: second cycle into a protected block starts nothing
    p_lock_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_PROG_ARM || r_q.st == ST_ERASE_ARM) && fire && locked) |=> !busy_o);

    // R4: clearing leaves no error bit set
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && fire && cmd == CMD_CLR_ERR) |=> (r_q.err == '0));

    // R5: timer completion ends the busy period
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        t_done |=> !busy_o);

endmodule

// File: tb/sim_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_flash_cmd_ctrl;
    localparam int         AW    = 6;
    localparam int         DW    = 8;
    localparam int         PCYC  = 4;
    localparam int         ECYC  = 12;
    localparam logic [7:0] MFR   = 8'hA7;
    localparam logic [7:0] DEV   = 8'h5E;
    localparam int         NVEC  = 23;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic vpp_ok = 1'b1, hv_unlock = 1'b0, boot_wr_ok = 1'b0, busy_o;
    int checks = 0, failures = 0;
    int nb;

    always #10 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYC(PCYC), .ERASE_CYC(ECYC),
                     .MFR_ID(MFR), .DEV_ID(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr),
        .wdata(wdata), .rdata(rdata), .vpp_ok(vpp_ok), .hv_unlock(hv_unlock),
        .boot_wr_ok(boot_wr_ok), .busy_o(busy_o));

    // {write, requirement number, address, data, expected read}
    localparam logic [26:0] VECS [NVEC] = '{
        {1'b0, 4'd1,  6'd5,  8'h00, 8'hFF},   // R1 erased at reset
        {1'b1, 4'd3,  6'd0,  8'h90, 8'h00},
        {1'b0, 4'd3,  6'd0,  8'h00, 8'hA7},   // R3 maker byte
        {1'b0, 4'd3,  6'd1,  8'h00, 8'h5E},   // R3 device byte
        {1'b0, 4'd3,  6'd3,  8'h00, 8'h5E},
        {1'b1, 4'd3,  6'd0,  8'hFF, 8'h00},
        {1'b0, 4'd3,  6'd3,  8'h00, 8'hFF},
        {1'b1, 4'd4,  6'd0,  8'h70, 8'h00},
        {1'b0, 4'd4,  6'd0,  8'h00, 8'h80},   // R4 clean status
        {1'b1, 4'd11, 6'd0,  8'h00, 8'h00},
        {1'b0, 4'd11, 6'd0,  8'h00, 8'hB0},   // R11 reserved 00h
        {1'b1, 4'd4,  6'd0,  8'h50, 8'h00},
        {1'b0, 4'd4,  6'd0,  8'h00, 8'h80},   // R4 cleared
        {1'b1, 4'd11, 6'd0,  8'hFF, 8'h00},
        {1'b1, 4'd11, 6'd0,  8'hE7, 8'h00},
        {1'b0, 4'd11, 6'd0,  8'h00, 8'hB0},   // R11 selects status
        {1'b1, 4'd4,  6'd0,  8'h50, 8'h00},
        {1'b1, 4'd7,  6'd16, 8'h20, 8'h00},
        {1'b1, 4'd7,  6'd16, 8'hFF, 8'h00},
        {1'b0, 4'd7,  6'd0,  8'h00, 8'hB0},   // R7 bad confirm
        {1'b1, 4'd7,  6'd0,  8'h50, 8'h00},
        {1'b1, 4'd7,  6'd0,  8'hFF, 8'h00},
        {1'b0, 4'd7,  6'd16, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; cs_n = 1'b0; we_n = 1'b0;
        @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        addr = a; #1;
        check(req, rdata, exp);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_o && n < 1000) begin n++; @(negedge clk); end
    endtask

    initial begin
        #(20 * 50000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy", busy_o, 0);

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i][26])
                wr(VECS[i][21:16], VECS[i][15:8]);
            else
                rd($sformatf("R%0d vec%0d", VECS[i][25:22], i), VECS[i][21:16], VECS[i][7:0]);
        end

        // R2: no effect while strobes stay low; releasing cs_n alone completes it
        wr(0, 8'hFF);
        @(negedge clk); addr = 6'd9; wdata = 8'h70; cs_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        #1 check("R2 held", rdata, 8'hFF);
        cs_n = 1'b1;
        @(negedge clk); #1 check("R2 cs release", rdata, 8'h80);
        we_n = 1'b1;

        // R5/R12: program with busy window, then AND semantics
        wr(6'd20, 8'h40);
        wr(6'd20, 8'hF0);
        check("R5 busy", busy_o, 1);
        rd("R5 bit7 busy R12", 6'd20, 8'h00);
        count_busy(nb);
        check("R5 busy cycles", nb, PCYC);
        rd("R5 ready", 6'd20, 8'h80);
        wr(6'd20, 8'h10);
        wr(6'd20, 8'h3C);
        count_busy(nb);
        wr(0, 8'hFF);
        rd("R5 and", 6'd20, 8'h30);

        // R6: erase block 1, block 2 untouched
        wr(6'd40, 8'h40); wr(6'd40, 8'h0F); count_busy(nb);
        wr(6'd17, 8'h20);
        wr(6'd17, 8'hD0);
        count_busy(nb);
        check("R6 busy cycles", nb, ECYC);
        wr(0, 8'hFF);
        rd("R6 erased", 6'd20, 8'hFF);
        rd("R6 other block", 6'd40, 8'h0F);

        // R9: supply low
        vpp_ok = 1'b0;
        wr(6'd30, 8'h40); wr(6'd30, 8'h00);
        check("R9 no busy", busy_o, 0);
        rd("R9 prog status", 0, 8'h98);
        wr(0, 8'h50);
        wr(6'd40, 8'h20); wr(6'd40, 8'hD0);
        rd("R9 erase status", 0, 8'hA8);
        wr(0, 8'h50);
        vpp_ok = 1'b1;
        wr(0, 8'hFF);
        rd("R9 array kept", 6'd30, 8'hFF);
        rd("R9 block kept", 6'd40, 8'h0F);

        // R10: protected block 0
        wr(6'd2, 8'h40); wr(6'd2, 8'h55);
        rd("R10 prog locked", 0, 8'h90);
        wr(0, 8'h50);
        wr(6'd2, 8'h20); wr(6'd2, 8'hD0);
        rd("R10 erase locked", 0, 8'hA0);
        wr(0, 8'h50); wr(0, 8'hFF);
        rd("R10 unchanged", 6'd2, 8'hFF);
        boot_wr_ok = 1'b1;
        wr(6'd2, 8'h40); wr(6'd2, 8'h55); count_busy(nb);
        boot_wr_ok = 1'b0; hv_unlock = 1'b1;
        wr(6'd2, 8'h40); wr(6'd2, 8'h11); count_busy(nb);
        hv_unlock = 1'b0;
        wr(0, 8'hFF);
        rd("R10 unlocked prog", 6'd2, 8'h11);

        // R8: pause, restricted commands, resume for the remaining count
        wr(6'd44, 8'h40); wr(6'd44, 8'h00); count_busy(nb);
        wr(6'd44, 8'h20); wr(6'd44, 8'hD0);
        repeat (3) @(negedge clk);
        wr(0, 8'hB0);   // timer has advanced 6 cycles by this point
        check("R8 paused not busy", busy_o, 0);
        rd("R8 paused status", 0, 8'hC0);
        wr(6'd50, 8'h40);
        wr(6'd50, 8'h70);
        check("R8 40h ignored busy", busy_o, 0);
        rd("R8 40h ignored status", 0, 8'hC0);
        wr(0, 8'h90);
        rd("R8 90h ignored", 6'd1, 8'hC0);
        wr(0, 8'hFF);
        rd("R8 old contents", 6'd44, 8'h00);
        rd("R8 no stray program", 6'd50, 8'hFF);
        wr(0, 8'hD0);
        count_busy(nb);
        check("R8 remaining cycles", nb, ECYC - 6);
        wr(0, 8'hFF);
        rd("R8 erased after resume", 6'd44, 8'hFF);
        rd("R8 other block", 6'd20, 8'hFF);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule